// File: doc/BRIEF.md
# Ring-Oscillator Phase Quantizer Back End

This block is the digital back end of an open-loop converter built around a free-running inverter ring oscillator. On each enabled sample clock edge it captures every tap of the ring in parallel. For each stage it compares the new bit with the bit taken at the previous sample. It then counts the stages that changed and registers that count as the output code. The code is the ring's phase advance over one sample period. This is the first difference of the quantized phase, so quantization error is first-order noise shaped while the input is delayed by one sample.

The analog ring sits outside the block. The taps reach the block asynchronously, and a parameter can add a two-flop synchronizer per tap. The system must run the oscillator slowly enough that no stage toggles twice within one sample period. The block raises a flag when every stage toggles in one sample, which is the largest advance it can resolve.

Top module: `phase_toggle_quantizer`

## Requirements
- R1: While `rst` is high on a clock edge, the next outputs are `sampleCode` = 0, `sampleValid` = 0 and `overflowFlag` = 0.
- R2: A valid `sampleCode` equals the number of ring taps, from 0 to 11, whose captured value differs between two consecutive captures. Bit i of `ringTaps` is stage i.
- R3: With no synchronizer, taps captured at enabled edge j yield their code after enabled edge j+1, together with a one-cycle `sampleValid` pulse.
- R4: After reset, `sampleValid` stays low for the first two enabled edges and first rises after the third (without synchronizer).
- R5: On an edge where `sampleEn` is low, nothing is captured, `sampleCode` holds its value and `sampleValid` is low. The next enabled capture reports the edges accumulated since the last capture.
- R6: `overflowFlag` is high exactly on valid samples where all 11 stages toggled, so the code is 11.
- R7: With `SYNC_STAGES` = 2, each result appears two enabled edges later, and the first valid pulse moves from the third to the fifth enabled edge.
- R8: A reset asserted during operation discards the stored phase, and the valid sequence restarts as in R4.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Sample enable; the whole pipeline advances only when high |
| ringTaps | input | 11 | Asynchronous ring stage outputs, bit i is stage i |
| sampleCode | output | 4 | Number of stages that toggled in the sample period |
| sampleValid | output | 1 | One-cycle strobe marking a new valid code |
| overflowFlag | output | 1 | All stages toggled in this sample |

## Verification
The bench counts enabled edges only. It keeps a history of the edges the ring model advanced between captures. Without a synchronizer, the code checked after capture j is the advance recorded for capture j-1, and it is valid from capture 3 on. The synchronized instance runs in parallel and is checked against the advance for capture j-3, valid from capture 5 on. Every output is sampled on the falling clock edge after the enabled rising edge that produces it. On cycles with the enable low, the bench checks that the code is unchanged and that valid is low.

// File: rtl/rpq_pkg.sv
package rpq_pkg;
  // strobes from the control to the datapath, one set per clock
  typedef struct packed {
    logic advance;    // capture a new sample and shift the pipeline
    logic emitValid;  // the code loaded on this edge is meaningful
  } rpq_ctrl_t;
endpackage

// File: rtl/rpq_tap_cell.sv
module rpq_tap_cell #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic tapIn,
  output logic toggle
);
  logic syncOut;
  logic capCur;
  logic capPrev;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign syncOut = tapIn;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncReg;
      always_ff @(posedge clk) begin
        if (rst) begin
          syncReg <= '0;
        end else if (advance) begin
          syncReg[0] <= tapIn;
          for (int k = 1; k < SYNC_STAGES; k++) begin
            syncReg[k] <= syncReg[k-1];
          end
        end
      end
      assign syncOut = syncReg[SYNC_STAGES-1];
    end
  endgenerate

  // current and previous captured phase bit of this stage
  always_ff @(posedge clk) begin
    if (rst) begin
      capCur  <= 1'b0;
      capPrev <= 1'b0;
    end else if (advance) begin
      capCur  <= syncOut;
      capPrev <= capCur;
    end
  end

  assign toggle = capCur ^ capPrev;
endmodule

// File: rtl/rpq_datapath.sv
module rpq_datapath
  import rpq_pkg::*;
#(
  parameter int NUM_TAPS    = 11,
  parameter int SYNC_STAGES = 0,
  parameter int CODE_W      = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  rpq_ctrl_t           ctrl,
  input  logic [NUM_TAPS-1:0] ringTaps,
  output logic [CODE_W-1:0]   codeOut,
  output logic                fullToggle
);
  logic [NUM_TAPS-1:0] toggles;
  logic [CODE_W-1:0]   toggleCount;

  generate
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_stage
      rpq_tap_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .advance (ctrl.advance),
        .tapIn   (ringTaps[i]),
        .toggle  (toggles[i])
      );
    end
  endgenerate

  function automatic logic [CODE_W-1:0] countOnes(input logic [NUM_TAPS-1:0] v);
    logic [CODE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      acc = acc + CODE_W'(v[i]);
    end
    return acc;
  endfunction

  assign toggleCount = countOnes(toggles);

  always_ff @(posedge clk) begin
    if (rst) begin
      codeOut <= '0;
    end else if (ctrl.advance) begin
      codeOut <= toggleCount;
    end
  end

  // every stage moved in one period: the largest resolvable advance
  always_ff @(posedge clk) begin
    if (rst) begin
      fullToggle <= 1'b0;
    end else begin
      fullToggle <= ctrl.emitValid & (&toggles);
    end
  end
endmodule

// File: rtl/rpq_control.sv
module rpq_control
  import rpq_pkg::*;
#(
  parameter int SYNC_STAGES = 0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleEn,
  output rpq_ctrl_t ctrl,
  output logic      validOut
);
  // captures needed before both phase registers hold real taps
  localparam int FILL_NEED = SYNC_STAGES + 2;
  localparam int FILL_W    = $clog2(FILL_NEED + 1);
  localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(FILL_NEED);

  logic [FILL_W-1:0] fillCnt;
  logic              primed;

  assign primed         = (fillCnt == FILL_TOP);
  assign ctrl.advance   = sampleEn;
  assign ctrl.emitValid = sampleEn & primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (sampleEn && !primed) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
    end else begin
      validOut <= ctrl.emitValid;
    end
  end
endmodule

// File: rtl/phase_toggle_quantizer.sv
module phase_toggle_quantizer
  import rpq_pkg::*;
#(
  parameter int NUM_TAPS    = 11,
  parameter int SYNC_STAGES = 0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sampleEn,
  input  logic [NUM_TAPS-1:0]               ringTaps,
  output logic [$clog2(NUM_TAPS+1)-1:0]     sampleCode,
  output logic                              sampleValid,
  output logic                              overflowFlag
);
  localparam int CODE_W = $clog2(NUM_TAPS + 1);

  rpq_ctrl_t ctrl;

  rpq_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sampleEn (sampleEn),
    .ctrl     (ctrl),
    .validOut (sampleValid)
  );

  rpq_datapath #(
    .NUM_TAPS    (NUM_TAPS),
    .SYNC_STAGES (SYNC_STAGES),
    .CODE_W      (CODE_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .ringTaps   (ringTaps),
    .codeOut    (sampleCode),
    .fullToggle (overflowFlag)
  );
endmodule

// File: rtl/phase_toggle_quantizer_chk.sv
module phase_toggle_quantizer_chk #(
  parameter int NUM_TAPS = 11
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          sampleEn,
  input logic [$clog2(NUM_TAPS+1)-1:0] sampleCode,
  input logic                          sampleValid,
  input logic                          overflowFlag
);
  localparam int CODE_W = $clog2(NUM_TAPS + 1);
  localparam logic [CODE_W-1:0] FULL = CODE_W'(NUM_TAPS);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sampleValid && sampleCode == '0 && !overflowFlag));

  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    sampleCode <= FULL);

  a_r4_no_valid_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sampleValid);

  a_r5_hold_code: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> $stable(sampleCode));

  a_r5_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> !sampleValid);

  a_r6_flag_means_full: assert property (@(posedge clk) disable iff (rst)
    overflowFlag |-> (sampleValid && sampleCode == FULL));

  a_r6_full_means_flag: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && sampleCode == FULL) |-> overflowFlag);
endmodule

bind phase_toggle_quantizer phase_toggle_quantizer_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sampleEn     (sampleEn),
  .sampleCode   (sampleCode),
  .sampleValid  (sampleValid),
  .overflowFlag (overflowFlag)
);

// File: tb/phase_toggle_quantizer_tb.sv
module phase_toggle_quantizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 11;
  localparam int RING_STATES = 2 * TAPS;

  logic            clk;
  logic            rst;
  logic            sampleEn;
  logic [TAPS-1:0] ringTaps;
  logic [3:0]      code0, code2;
  logic            valid0, valid2, ovf0, ovf2;

  int testsRun = 0;
  int testsFailed = 0;
  int phase = 0;
  int pend = 0;
  int nCap = 0;
  int hist [0:1023];

  phase_toggle_quantizer #(.NUM_TAPS(TAPS), .SYNC_STAGES(0)) u_dut (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .ringTaps(ringTaps),
    .sampleCode(code0), .sampleValid(valid0), .overflowFlag(ovf0)
  );

  phase_toggle_quantizer #(.NUM_TAPS(TAPS), .SYNC_STAGES(2)) u_dut_sync (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .ringTaps(ringTaps),
    .sampleCode(code2), .sampleValid(valid2), .overflowFlag(ovf2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ring model: one stage flips per edge, 22 states per full cycle
  function automatic logic [TAPS-1:0] ringPattern(input int p);
    logic [TAPS-1:0] b;
    for (int i = 0; i < TAPS; i++) begin
      if (p < TAPS) b[i] = (i < p);
      else          b[i] = (i >= p - TAPS);
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  // advance the ring by 'step' edges, present one clock, check both instances
  task automatic sampleCycle(input int step, input bit en, input string req);
    logic [3:0] hold0, hold2;
    int e0, e2;
    bit v0, v2;
    hold0 = code0;
    hold2 = code2;
    phase = (phase + step) % RING_STATES;
    pend += step;
    ringTaps = ringPattern(phase);
    sampleEn = en;
    @(negedge clk);
    if (en) begin
      nCap++;
      hist[nCap] = pend;
      pend = 0;
      v0 = (nCap >= 3);
      check(valid0 == v0, {req, " R4 valid"}, int'(valid0), int'(v0));
      if (v0) begin
        e0 = hist[nCap-1];
        check(code0 == 4'(e0), {req, " R2 R3 code"}, int'(code0), e0);
        check(ovf0 == (e0 == TAPS), {req, " R6 overflow"}, int'(ovf0), int'(e0 == TAPS));
      end
      v2 = (nCap >= 5);
      check(valid2 == v2, {req, " R7 sync valid"}, int'(valid2), int'(v2));
      if (v2) begin
        e2 = hist[nCap-3];
        check(code2 == 4'(e2), {req, " R7 sync code"}, int'(code2), e2);
      end
    end else begin
      check(valid0 == 1'b0, {req, " R5 idle valid"}, int'(valid0), 0);
      check(code0 == hold0, {req, " R5 idle hold"}, int'(code0), int'(hold0));
      check(code2 == hold2, {req, " R5 R7 idle hold"}, int'(code2), int'(hold2));
    end
  endtask

  task automatic doReset(input string req);
    rst = 1'b1;
    sampleEn = 1'b0;
    repeat (2) @(negedge clk);
    check(code0 == 4'd0 && code2 == 4'd0, {req, " R1 code"}, int'(code0), 0);
    check(!valid0 && !valid2, {req, " R1 valid"}, int'(valid0), 0);
    check(!ovf0 && !ovf2, {req, " R1 overflow"}, int'(ovf0), 0);
    rst = 1'b0;
    nCap = 0;
    pend = 0;
  endtask

  task automatic testReset();
    doReset("reset");
  endtask

  task automatic testSteady();
    for (int k = 0; k < 20; k++) sampleCycle(3, 1'b1, "steady");
  endtask

  task automatic testVaried();
    for (int k = 0; k < 36; k++) sampleCycle((k * 7) % 12, 1'b1, "varied");
  endtask

  task automatic testZero();
    for (int k = 0; k < 8; k++) sampleCycle(0, 1'b1, "zero");
  endtask

  task automatic testOverflow();
    for (int k = 0; k < 12; k++) sampleCycle((k % 2 == 0) ? 11 : 10, 1'b1, "overflow R6");
  endtask

  task automatic testEnable();
    for (int k = 0; k < 6; k++) sampleCycle(1, 1'b1, "enable");
    sampleCycle(2, 1'b0, "enable");
    sampleCycle(3, 1'b0, "enable");
    sampleCycle(1, 1'b0, "enable");
    sampleCycle(2, 1'b1, "enable R5 accumulate");
    for (int k = 0; k < 6; k++) sampleCycle(4, 1'b1, "enable");
  endtask

  task automatic testMidReset();
    for (int k = 0; k < 5; k++) sampleCycle(5, 1'b1, "midrun");
    doReset("R8 midrun");
    for (int k = 0; k < 10; k++) sampleCycle(6, 1'b1, "R8 restart");
  endtask

  initial begin
    rst = 1'b1;
    sampleEn = 1'b0;
    ringTaps = '0;
    @(negedge clk);
    testReset();
    testSteady();
    testVaried();
    testZero();
    testOverflow();
    testEnable();
    testMidReset();
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end
endmodule